// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a 16-bit up-counter driven by a prescaled version of its clock. It counts until it equals a programmable 16-bit limit, then returns to zero on the next counting edge and raises a sticky overflow flag. When the interrupt enable bit is set, the flag drives an interrupt request output.

Software reaches the block through a byte-wide register port with separate read and write strobes and a 3-bit address. An 8-bit control register holds the flag, the interrupt enable, a stop bit, a self-clearing counter-reset bit and a 3-bit divider select. The counter and the limit can each be read and written one byte at a time. The flag is cleared in two steps. First software reads the control register while the flag is set, then it writes 0 to the flag. If an overflow lands between the read and the write, the flag stays set, so no interrupt request can be dropped.

Top module: `modtmr_top`

## Requirements
- R1: After reset the control register reads 0x20 (stopped, every other bit 0), the counter reads 0x0000, the limit reads 0xFFFF and `irq` is 0.
- R2: Address map: 0 = control, 1 = counter high byte, 2 = counter low byte, 3 = limit high byte, 4 = limit low byte, and addresses 5 to 7 read 0. Control bits: bit 7 flag, bit 6 interrupt enable, bit 5 stop, bit 4 counter reset, bit 3 unused, bits 2:0 divider select. Bits 4 and 3 always read 0.
- R3: With divider select n, the counter advances once every 2^n clocks for n from 0 to 6. Select 7 divides by 64.
- R4: On a counting edge the counter loads 0 if it equals the limit, and otherwise adds 1. A limit of 0xFFFF makes it wrap from 0xFFFF to 0.
- R5: The flag becomes 1 on every counting edge at which the counter wraps to 0.
- R6: A write of 0 to bit 7 clears the flag only when it follows a control read that saw the flag at 1. Without that read, the flag stays 1.
- R7: If a wrap occurs after the arming read and before the write of 0, the flag stays 1.
- R8: Writing 1 to bit 7 never changes the flag.
- R9: While the stop bit is 1, neither the counter nor the divider advances.
- R10: Writing 1 to bit 4 clears the counter and the divider on that clock edge. The bit does not stay set.
- R11: `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R12: Byte writes to the counter and limit addresses replace only the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe; a control read can arm the flag clear |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The divider is swept over all eight select values with a wide limit. This separates each division ratio, including the capped select 7. Several limits from 0 up to 255 are run with two divider settings over a run length that is not a multiple of any period. The final count and flag then show whether the wrap happens at the limit or one step off, and a limit of 0 shows a wrap on every tick. A counter preloaded near 0xFFFF shows the free-running wrap. The flag is driven through clear with a read, clear without a read, clear with an overflow between the two steps, and a write of 1, which separates the arming rules from a plain write.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 6;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd4;

  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_STOP = 5;
  localparam int B_CRST = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  // Mask of divider bits that must all be 1 for a counting tick.
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    int n;
    n = (int'(sel) > PRE_W) ? PRE_W : int'(sel);
    return PRE_W'((1 << n) - 1);
  endfunction

  // Next counter value on a counting edge.
  function automatic cnt_t step_count(input cnt_t cur, input cnt_t lim);
    return (cur == lim) ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/modtmr_prescaler.sv
module modtmr_prescaler
  import modtmr_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [W-1:0] pre_q;
  logic [W-1:0] mask;

  assign mask = W'(div_mask(sel));
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/modtmr_counter.sv
module modtmr_counter
  import modtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [7:0] wdata,
  input  cnt_t       lim,
  output cnt_t       cnt_q,
  output logic       ovf
);
  localparam int HB = CNT_W - 8;

  logic any_wr;
  assign any_wr = wr_hi || wr_lo;
  // Wrap event: a counting edge at the limit that no write or reset overrides.
  assign ovf = tick && (cnt_q == lim) && !any_wr && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (wr_hi) cnt_q[CNT_W-1:HB] <= wdata;
    else if (wr_lo) cnt_q[7:0] <= wdata;
    else if (tick)  cnt_q <= step_count(cnt_q, lim);
  end
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
  import modtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  cnt_t              cnt_q,
  input  logic              ovf,
  output logic [7:0]        bus_rdata,
  output logic              ie_q,
  output logic              stop_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              flag_q,
  output logic              arm_q,
  output logic              crst,
  output logic              wr_ctrl,
  output logic              cnt_wr_hi,
  output logic              cnt_wr_lo,
  output cnt_t              lim_q
);
  localparam int HB = CNT_W - 8;

  logic rd_ctrl;

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign rd_ctrl   = bus_rd && (bus_addr == A_CTRL);
  assign crst      = wr_ctrl && bus_wdata[B_CRST];
  assign cnt_wr_hi = bus_wr && (bus_addr == A_CNT_HI);
  assign cnt_wr_lo = bus_wr && (bus_addr == A_CNT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      stop_q <= 1'b1;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      ie_q   <= bus_wdata[B_IE];
      stop_q <= bus_wdata[B_STOP];
      sel_q  <= bus_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '1;
    end else if (bus_wr && (bus_addr == A_LIM_HI)) begin
      lim_q[CNT_W-1:HB] <= bus_wdata;
    end else if (bus_wr && (bus_addr == A_LIM_LO)) begin
      lim_q[7:0] <= bus_wdata;
    end
  end

  // Flag and clear handshake: a wrap sets the flag and disarms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (ovf) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (wr_ctrl) begin
      if (arm_q && !bus_wdata[B_FLAG]) flag_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (rd_ctrl && flag_q) begin
      arm_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = {flag_q, ie_q, stop_q, 1'b0, 1'b0, sel_q};
      A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:HB];
      A_CNT_LO: bus_rdata = cnt_q[7:0];
      A_LIM_HI: bus_rdata = lim_q[CNT_W-1:HB];
      A_LIM_LO: bus_rdata = lim_q[7:0];
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  logic             ie_q, stop_q, flag_q, arm_q;
  logic             crst, wr_ctrl, cnt_wr_hi, cnt_wr_lo, cnt_wr;
  logic [SEL_W-1:0] sel_q;
  logic             tick, ovf_evt;
  cnt_t             cnt_q, lim_q;

  assign cnt_wr = cnt_wr_hi || cnt_wr_lo;
  assign irq    = flag_q && ie_q;

  modtmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q), .ovf(ovf_evt),
    .bus_rdata(bus_rdata), .ie_q(ie_q), .stop_q(stop_q), .sel_q(sel_q),
    .flag_q(flag_q), .arm_q(arm_q), .crst(crst), .wr_ctrl(wr_ctrl),
    .cnt_wr_hi(cnt_wr_hi), .cnt_wr_lo(cnt_wr_lo), .lim_q(lim_q)
  );

  modtmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(!stop_q), .clr(crst), .sel(sel_q), .tick(tick)
  );

  modtmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(crst), .wr_hi(cnt_wr_hi),
    .wr_lo(cnt_wr_lo), .wdata(bus_wdata), .lim(lim_q), .cnt_q(cnt_q), .ovf(ovf_evt)
  );
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk
  import modtmr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ovf,
  input cnt_t       cnt,
  input logic       flag,
  input logic       arm,
  input logic       irq,
  input logic       stop,
  input logic       cnt_wr,
  input logic       crst,
  input logic       wr_ctrl,
  input logic [7:0] wdata
);
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);

  p_clear_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(arm) && $past(wr_ctrl) && !$past(ovf)));

  p_one_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_ctrl && wdata[B_FLAG]) |=> flag);

  p_stop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cnt_wr && !crst) |=> $stable(cnt));

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind modtmr_top modtmr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ovf(ovf_evt), .cnt(cnt_q), .flag(flag_q),
  .arm(arm_q), .irq(irq), .stop(stop_q), .cnt_wr(cnt_wr), .crst(crst),
  .wr_ctrl(wr_ctrl), .wdata(bus_wdata)
);

// File: tb/test_modtmr_top.sv
`timescale 1ns/1ps
module test_modtmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  modtmr_top i_modtmr_top (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] a, output int v);
    logic [7:0] h, l;
    rd(a, h); rd(a + 3'd1, l);
    v = {h, l};
  endtask

  // Read-then-write-0 clear while stopped.
  task automatic clear_flag(input logic ie);
    logic [7:0] d;
    rd(3'd0, d);
    wr(3'd0, {1'b0, ie, 1'b1, 5'b0});
  endtask

  // Run d_len counting edges from a cleared counter and divider.
  task automatic run(input int lim, input int sel, input logic ie, input int d_len, input logic do_rst);
    wr(3'd3, 8'(lim >> 8)); wr(3'd4, 8'(lim));
    clear_flag(ie);
    wr(3'd0, {1'b0, ie, 1'b0, do_rst, 1'b0, 3'(sel)});
    repeat (d_len - 1) @(negedge clk);
    wr(3'd0, {1'b0, ie, 1'b1, 2'b0, 3'(sel)});
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int v, t, sh, held;
    int lims[6] = '{0, 1, 2, 5, 9, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map
    rd(3'd0, d);  chk("R1 ctrl", d, 8'h20);
    rd16(3'd1, v); chk("R1 count", v, 0);
    rd16(3'd3, v); chk("R1 limit", v, 16'hFFFF);
    chk("R1 irq", irq, 0);
    rd(3'd7, d);  chk("R2 unmapped", d, 0);

    // R12 byte writes
    wr(3'd3, 8'h12); rd16(3'd3, v); chk("R12 limit hi", v, 16'h12FF);
    wr(3'd4, 8'h34); rd16(3'd3, v); chk("R12 limit lo", v, 16'h1234);
    wr(3'd2, 8'h56); rd16(3'd1, v); chk("R12 count lo", v, 16'h0056);

    // R3 divider sweep
    for (int s = 0; s < 8; s++) begin
      run(16'hFFFF, s, 1'b0, 200, 1'b1);
      sh = (s > 6) ? 6 : s;
      rd16(3'd1, v); chk($sformatf("R3 sel %0d", s), v, 200 >> sh);
    end

    // R4/R5/R11 limit sweep
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 6; k++) begin
        logic ie;
        ie = logic'(k % 2);
        run(lims[k], p, ie, 37, 1'b1);
        t = 37 >> p;
        rd16(3'd1, v); chk($sformatf("R4 lim %0d", lims[k]), v, t % (lims[k] + 1));
        rd(3'd0, d);
        chk($sformatf("R5 flag lim %0d", lims[k]), d[7], (t >= lims[k] + 1) ? 1 : 0);
        chk("R11 irq", irq, ((t >= lims[k] + 1) && ie) ? 1 : 0);
        chk("R2 ctrl readback", d[6:0], {ie, 1'b1, 2'b00, 3'(p)});
      end
    end

    // R4 free-running wrap from a preloaded count
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    clear_flag(1'b0);
    wr(3'd1, 8'hFF); wr(3'd2, 8'hF0);
    wr(3'd0, 8'h00);
    repeat (19) @(negedge clk);
    wr(3'd0, 8'h20);
    rd16(3'd1, v); chk("R4 free run", v, 4);
    rd(3'd0, d); chk("R5 free run flag", d[7], 1);

    // R9 stop holds counter and divider
    run(16'hFFFF, 2, 1'b0, 6, 1'b1);
    repeat (50) @(negedge clk);
    rd16(3'd1, held); chk("R9 held count", held, 1);
    wr(3'd0, 8'h02);
    @(negedge clk);
    wr(3'd0, 8'h22);
    rd16(3'd1, v); chk("R9 divider held", v, 2);

    // R10 counter reset bit
    wr(3'd0, 8'h38);
    rd(3'd0, d); chk("R10 bit4 reads 0", d, 8'h20);
    rd16(3'd1, v); chk("R10 count cleared", v, 0);

    // R6 write 0 without arming read
    run(3, 0, 1'b1, 10, 1'b1);
    wr(3'd0, 8'h60);
    #1 chk("R6 no read irq", irq, 1);
    rd(3'd0, d); chk("R6 no read keeps flag", d[7], 1);
    // R6 clear after arming read (that read armed it)
    wr(3'd0, 8'h60);
    rd(3'd0, d); chk("R6 cleared", d[7], 0);
    chk("R11 irq low", irq, 0);

    // R8 write 1 has no effect
    wr(3'd0, 8'hE0);
    rd(3'd0, d); chk("R8 write one", d[7], 0);

    // R7 overflow between read and write
    run(3, 0, 1'b1, 10, 1'b1);
    wr(3'd0, 8'h40);
    rd(3'd0, d); chk("R7 flag before", d[7], 1);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h60);
    rd(3'd0, d); chk("R7 flag kept", d[7], 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule